// File: doc/BRIEF.md
# Transmit and Relay Egress Arbiter

This block decides which of two packet sources may drive a single egress MAC port. One source is the local transmit path fed by a DMA engine. The other is a relay path that forwards frames received on another port. Each source raises a request and holds it. The block answers with a grant that stays asserted for the whole frame, until that source pulses its end-of-frame input. Frames are never cut short.

A 3-bit policy field chooses how contention is resolved. The choices are alternating service, a fixed winner on the transmit side, or a fixed winner on the relay side. Two further policies start from alternating service or from transmit preference. They fall back to relay preference whenever the relay FIFO occupancy is strictly above an 8-bit threshold. That comparison is made only at the moment a new grant is chosen. Policy and threshold sit in one 32-bit configuration word behind a simple write strobe with combinational read-back. Once the relay-enable input is high, the word no longer accepts writes, so the policy cannot change under live forwarding.

Top module: `egress_arb`

## Requirements
- R1: After reset both grants are low, the configuration word reads 0 (alternating policy, threshold 0), and the first contested decision goes to the transmit source.
- R2: Policy value 0 alternates grants between the two sources when both request at a decision; the source served last loses the tie.
- R3: Policy value 1 grants the transmit source whenever it requests at a decision.
- R4: Policy value 2 grants the relay source whenever it requests at a decision.
- R5: Policy value 4 grants the relay source on a tie when occupancy is strictly greater than the threshold, and otherwise alternates as in R2 (occupancy equal to the threshold does not trigger the override).
- R6: Policy value 5 grants the relay source on a tie when occupancy is strictly greater than the threshold, and otherwise favours the transmit source.
- R7: Policy values 3, 6 and 7 arbitrate exactly as policy 0; the written value is still read back.
- R8: The configuration word holds the policy in bits 14:12 and the threshold in bits 7:0; every other bit reads 0 regardless of what is written.
- R9: While relay-enable is high, writes to the configuration word are ignored and the read-back value does not change.
- R10: At most one grant is high. A grant stays high until its own end-of-frame is seen, then both grants are low for one cycle before the next decision.
- R11: A source that requests alone while the port is idle is granted in the next cycle under every policy.
- R12: Occupancy changes while a frame is in progress have no effect on the current grant; the threshold matters only at a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| relay_en | input | 1 | Relay operation enabled; freezes the configuration |
| tx_req | input | 1 | Transmit source requests the port |
| tx_eof | input | 1 | Transmit source ends its frame |
| tx_gnt | output | 1 | Port granted to the transmit source |
| rl_req | input | 1 | Relay source requests the port |
| rl_eof | input | 1 | Relay source ends its frame |
| rl_gnt | output | 1 | Port granted to the relay source |
| rl_fill | input | 8 | Relay FIFO occupancy |

## Verification
A corrupted last-served bit shows as a repeated winner on the very next tie under policies 0, 3, 4, 6 and 7. It stays hidden under the fixed-priority policies until one of those comes back. A wrong ownership state shows within one cycle as two grants, a grant that drops before end-of-frame, or a missing idle gap. A bad comparison of threshold against occupancy appears only at a tie where the two values sit close together. The bench therefore drives occupancy just below, at and just above the threshold. A lost freeze appears in the read-back one cycle after the write.

// File: rtl/egress_arb_pkg.sv
package egress_arb_pkg;

  typedef enum logic [2:0] {
    POL_ALT     = 3'd0,
    POL_TX      = 3'd1,
    POL_RL      = 3'd2,
    POL_ALT_OVR = 3'd4,
    POL_TX_OVR  = 3'd5
  } policy_e;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RL   = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    BASE_ALT = 2'd0,
    BASE_TX  = 2'd1,
    BASE_RL  = 2'd2
  } base_e;

endpackage

// File: rtl/egress_arb_rst_sync.sv
module egress_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/egress_arb_cfg.sv
module egress_arb_cfg #(
  parameter int WORD_W   = 32,
  parameter int POL_W    = 3,
  parameter int POL_LSB  = 12,
  parameter int LEVEL_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               frozen,
  output logic [POL_W-1:0]   policy,
  output logic [LEVEL_W-1:0] level,
  output logic [WORD_W-1:0]  rdata
);

  localparam int POL_MSB = POL_LSB + POL_W - 1;

  logic               wr_ok;
  logic [POL_W-1:0]   policy_q, policy_d;
  logic [LEVEL_W-1:0] level_q, level_d;

  assign wr_ok = wr && !frozen;

  always_comb begin
    policy_d = policy_q;
    level_d  = level_q;
    if (wr_ok) begin
      policy_d = wdata[POL_MSB:POL_LSB];
      level_d  = wdata[LEVEL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      policy_q <= '0;
      level_q  <= '0;
    end else if (wr_ok) begin
      policy_q <= policy_d;
      level_q  <= level_d;
    end
  end

  always_comb begin
    rdata                  = '0;
    rdata[POL_MSB:POL_LSB] = policy_q;
    rdata[LEVEL_W-1:0]     = level_q;
  end

  assign policy = policy_q;
  assign level  = level_q;

endmodule

// File: rtl/egress_arb_policy.sv
module egress_arb_policy
  import egress_arb_pkg::*;
#(
  parameter int POL_W   = 3,
  parameter int LEVEL_W = 8
) (
  input  logic [POL_W-1:0]   policy,
  input  logic [LEVEL_W-1:0] level,
  input  logic [LEVEL_W-1:0] fill,
  input  logic               last_rl,
  input  logic               tx_req,
  input  logic               rl_req,
  output logic               pick_tx,
  output logic               pick_rl
);

  base_e base;
  logic  ovr_en;
  logic  over;
  logic  tie_to_rl;

  always_comb begin
    base   = BASE_ALT;
    ovr_en = 1'b0;
    case (policy)
      POL_ALT:     begin base = BASE_ALT; ovr_en = 1'b0; end
      POL_TX:      begin base = BASE_TX;  ovr_en = 1'b0; end
      POL_RL:      begin base = BASE_RL;  ovr_en = 1'b0; end
      POL_ALT_OVR: begin base = BASE_ALT; ovr_en = 1'b1; end
      POL_TX_OVR:  begin base = BASE_TX;  ovr_en = 1'b1; end
      default:     begin base = BASE_ALT; ovr_en = 1'b0; end
    endcase
  end

  assign over = ovr_en && (fill > level);

  always_comb begin
    if (over) begin
      tie_to_rl = 1'b1;
    end else begin
      case (base)
        BASE_TX: tie_to_rl = 1'b0;
        BASE_RL: tie_to_rl = 1'b1;
        default: tie_to_rl = !last_rl;
      endcase
    end
  end

  always_comb begin
    pick_tx = 1'b0;
    pick_rl = 1'b0;
    if (tx_req && rl_req) begin
      pick_tx = !tie_to_rl;
      pick_rl = tie_to_rl;
    end else begin
      pick_tx = tx_req;
      pick_rl = rl_req;
    end
  end

endmodule

// File: rtl/egress_arb_owner.sv
module egress_arb_owner
  import egress_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pick_tx,
  input  logic pick_rl,
  input  logic tx_eof,
  input  logic rl_eof,
  output logic idle,
  output logic last_rl,
  output logic tx_gnt,
  output logic rl_gnt
);

  owner_e own_q, own_d;
  logic   last_q, last_d;
  logic   last_en;

  always_comb begin
    own_d   = own_q;
    last_d  = last_q;
    last_en = 1'b0;
    case (own_q)
      OWN_IDLE: begin
        if (pick_tx) begin
          own_d   = OWN_TX;
          last_d  = 1'b0;
          last_en = 1'b1;
        end else if (pick_rl) begin
          own_d   = OWN_RL;
          last_d  = 1'b1;
          last_en = 1'b1;
        end
      end
      OWN_TX:  if (tx_eof) own_d = OWN_IDLE;
      OWN_RL:  if (rl_eof) own_d = OWN_IDLE;
      default: own_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_IDLE;
    else        own_q <= own_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (last_en) last_q <= last_d;
  end

  assign idle    = (own_q == OWN_IDLE);
  assign last_rl = last_q;
  assign tx_gnt  = (own_q == OWN_TX);
  assign rl_gnt  = (own_q == OWN_RL);

endmodule

// File: rtl/egress_arb.sv
module egress_arb #(
  parameter int WORD_W     = 32,
  parameter int POL_W      = 3,
  parameter int POL_LSB    = 12,
  parameter int LEVEL_W    = 8,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               relay_en,
  input  logic               tx_req,
  input  logic               tx_eof,
  output logic               tx_gnt,
  input  logic               rl_req,
  input  logic               rl_eof,
  output logic               rl_gnt,
  input  logic [LEVEL_W-1:0] rl_fill
);

  logic               rst_n_int;
  logic [POL_W-1:0]   policy;
  logic [LEVEL_W-1:0] level;
  logic               last_rl;
  logic               idle;
  logic               pick_tx, pick_rl;

  egress_arb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  egress_arb_cfg #(
    .WORD_W  (WORD_W),
    .POL_W   (POL_W),
    .POL_LSB (POL_LSB),
    .LEVEL_W (LEVEL_W)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr     (cfg_wr),
    .wdata  (cfg_wdata),
    .frozen (relay_en),
    .policy (policy),
    .level  (level),
    .rdata  (cfg_rdata)
  );

  egress_arb_policy #(
    .POL_W   (POL_W),
    .LEVEL_W (LEVEL_W)
  ) u_pol (
    .policy  (policy),
    .level   (level),
    .fill    (rl_fill),
    .last_rl (last_rl),
    .tx_req  (tx_req && idle),
    .rl_req  (rl_req && idle),
    .pick_tx (pick_tx),
    .pick_rl (pick_rl)
  );

  egress_arb_owner u_own (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pick_tx (pick_tx),
    .pick_rl (pick_rl),
    .tx_eof  (tx_eof),
    .rl_eof  (rl_eof),
    .idle    (idle),
    .last_rl (last_rl),
    .tx_gnt  (tx_gnt),
    .rl_gnt  (rl_gnt)
  );

endmodule

// File: rtl/egress_arb_chk.sv
module egress_arb_chk #(
  parameter int WORD_W  = 32,
  parameter int POL_LSB = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              relay_en,
  input logic              tx_req,
  input logic              tx_eof,
  input logic              tx_gnt,
  input logic              rl_req,
  input logic              rl_eof,
  input logic              rl_gnt
);

  logic       port_idle;
  logic [2:0] pol;

  assign port_idle = !tx_gnt && !rl_gnt;
  assign pol       = cfg_rdata[POL_LSB+2:POL_LSB];

  AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_gnt && rl_gnt)); // R10

  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt && !tx_eof |=> tx_gnt); // R10

  AST_RL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rl_gnt && !rl_eof |=> rl_gnt); // R10

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt && tx_eof |=> port_idle); // R10

  AST_RL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rl_gnt && rl_eof |=> port_idle); // R10

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    relay_en && $past(relay_en) |-> $stable(cfg_rdata)); // R9

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[WORD_W-1:POL_LSB+3] == '0 && cfg_rdata[POL_LSB-1:8] == '0); // R8

  AST_LONE_TX: assert property (@(posedge clk) disable iff (!rst_n)
    port_idle && tx_req && !rl_req |=> tx_gnt); // R11

  AST_LONE_RL: assert property (@(posedge clk) disable iff (!rst_n)
    port_idle && rl_req && !tx_req |=> rl_gnt); // R11

  AST_TX_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    port_idle && tx_req && pol == 3'd1 |=> tx_gnt); // R3

  AST_RL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    port_idle && rl_req && pol == 3'd2 |=> rl_gnt); // R4

endmodule

bind egress_arb egress_arb_chk #(.WORD_W(WORD_W), .POL_LSB(POL_LSB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr    (cfg_wr),
  .cfg_rdata (cfg_rdata),
  .relay_en  (relay_en),
  .tx_req    (tx_req),
  .tx_eof    (tx_eof),
  .tx_gnt    (tx_gnt),
  .rl_req    (rl_req),
  .rl_eof    (rl_eof),
  .rl_gnt    (rl_gnt)
);

// File: tb/sim_egress_arb.sv
`timescale 1ns/1ps
module sim_egress_arb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        relay_en = 1'b0;
  logic        tx_req = 1'b0, tx_eof = 1'b0, tx_gnt;
  logic        rl_req = 1'b0, rl_eof = 1'b0, rl_gnt;
  logic [7:0]  rl_fill = '0;

  int    vectors = 0;
  int    misses  = 0;
  int    cycles  = 0;
  string cur_req = "R1";
  bit    checking = 1'b0;
  bit    done = 1'b0;

  // reference model state
  int m_own  = 0;   // 0 idle, 1 transmit, 2 relay
  int m_last = 1;   // 1: relay served last
  int m_pol  = 0;
  int m_lvl  = 0;

  always #10 clk = ~clk;

  egress_arb u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .relay_en(relay_en),
    .tx_req(tx_req), .tx_eof(tx_eof), .tx_gnt(tx_gnt),
    .rl_req(rl_req), .rl_eof(rl_eof), .rl_gnt(rl_gnt), .rl_fill(rl_fill)
  );

  function automatic bit relay_wins_tie();
    bit over;
    over = (m_pol == 4 || m_pol == 5) && (int'(rl_fill) > m_lvl);
    if (over) return 1'b1;
    if (m_pol == 1 || m_pol == 5) return 1'b0;
    if (m_pol == 2) return 1'b1;
    return (m_last == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_own = 0; m_last = 1; m_pol = 0; m_lvl = 0;
    end else begin
      if (m_own == 0) begin
        if (tx_req && rl_req) begin
          if (relay_wins_tie()) begin m_own = 2; m_last = 1; end
          else                  begin m_own = 1; m_last = 0; end
        end else if (tx_req) begin m_own = 1; m_last = 0; end
        else if (rl_req)     begin m_own = 2; m_last = 1; end
      end else if (m_own == 1) begin
        if (tx_eof) m_own = 0;
      end else begin
        if (rl_eof) m_own = 0;
      end
      if (cfg_wr && !relay_en) begin
        m_pol = int'(cfg_wdata[14:12]);
        m_lvl = int'(cfg_wdata[7:0]);
      end
    end
    cycles++;
  end

  always @(negedge clk) begin
    if (checking) begin
      logic [31:0] exp_rd;
      bit e_tx, e_rl;
      exp_rd = (32'(m_pol) << 12) | 32'(m_lvl);
      e_tx = (m_own == 1);
      e_rl = (m_own == 2);
      vectors++;
      if (tx_gnt !== e_tx || rl_gnt !== e_rl || cfg_rdata !== exp_rd) begin
        misses++;
        $display("FAIL %s t=%0t tx_gnt=%0b rl_gnt=%0b rdata=%h expected tx=%0b rl=%0b rdata=%h",
                 cur_req, $time, tx_gnt, rl_gnt, cfg_rdata, e_tx, e_rl, exp_rd);
      end
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = '0;
  endtask

  // fill_mode 0: any value, 1: around the threshold, 2: swings every cycle
  task automatic traffic(input int n, input int lvl, input int fill_mode,
                         input bit use_tx, input bit use_rl, input int eof_mod);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_req  = use_tx && (($urandom % 4) != 0);
      rl_req  = use_rl && (($urandom % 4) != 0);
      tx_eof  = (($urandom % eof_mod) == 0);
      rl_eof  = (($urandom % eof_mod) == 0);
      if (fill_mode == 1)      rl_fill = 8'(lvl - 1 + int'($urandom % 3));
      else if (fill_mode == 2) rl_fill = (i % 2 == 0) ? 8'hFF : 8'h00;
      else                     rl_fill = 8'($urandom);
    end
    @(negedge clk);
    tx_req = 0; rl_req = 0; tx_eof = 1; rl_eof = 1;
    @(negedge clk);
    tx_eof = 0; rl_eof = 0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    // R1: reset state and first tie goes to transmit
    cur_req = "R1";
    repeat (3) @(negedge clk);
    tx_req = 1; rl_req = 1;
    @(negedge clk);
    tx_req = 0; rl_req = 0;
    if (tx_gnt !== 1'b1) begin
      misses++;
      $display("FAIL R1 first tie tx_gnt=%0b expected 1", tx_gnt);
    end
    vectors++;
    tx_eof = 1; @(negedge clk); tx_eof = 0; @(negedge clk);

    cur_req = "R2";  traffic(400, 0, 0, 1, 1, 3);

    cur_req = "R8";
    write_cfg(32'hFFFF_FFFF);
    if (cfg_rdata !== 32'h0000_70FF) begin
      misses++;
      $display("FAIL R8 rdata=%h expected 000070ff", cfg_rdata);
    end
    vectors++;

    cur_req = "R7";  traffic(200, 0, 0, 1, 1, 3);
    write_cfg(32'h0000_3000); traffic(200, 0, 0, 1, 1, 3);
    write_cfg(32'h0000_6011); traffic(200, 0, 0, 1, 1, 3);

    cur_req = "R3";  write_cfg(32'h0000_1000); traffic(300, 0, 0, 1, 1, 3);
    cur_req = "R4";  write_cfg(32'h0000_2000); traffic(300, 0, 0, 1, 1, 3);
    cur_req = "R5";  write_cfg(32'h0000_4080); traffic(400, 128, 1, 1, 1, 2);
    write_cfg(32'h0000_4000); traffic(200, 1, 1, 1, 1, 2);
    cur_req = "R6";  write_cfg(32'h0000_5040); traffic(400, 64, 1, 1, 1, 2);
    cur_req = "R12"; write_cfg(32'h0000_5080); traffic(400, 0, 2, 1, 1, 6);
    cur_req = "R11"; traffic(200, 0, 0, 1, 0, 3); traffic(200, 0, 0, 0, 1, 3);
    cur_req = "R10"; write_cfg(32'h0000_0000); traffic(300, 0, 0, 1, 1, 8);

    cur_req = "R9";
    write_cfg(32'h0000_2033);
    @(negedge clk); relay_en = 1'b1;
    write_cfg(32'h0000_1044);
    write_cfg(32'hFFFF_FFFF);
    if (cfg_rdata !== 32'h0000_2033) begin
      misses++;
      $display("FAIL R9 rdata=%h expected 00002033", cfg_rdata);
    end
    vectors++;
    traffic(200, 0, 0, 1, 1, 3);

    checking = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  always @(posedge clk) begin
    if (!done && cycles > 150000) begin
      misses++;
      $display("FAIL watchdog expired in %s, cycles=%0d expected under 150000", cur_req, cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule